// File: doc/BRIEF.md
# DMA Word Address and Transfer Count Registers

This block holds the programmable state a DMA engine needs before and during a transfer: a word-aligned memory address, a remaining-word count, a direction flag and an enable. A processor programs it with memory-mapped writes. The count register takes its value from the data bus. The address register takes its value from the processor's own address lines, so the data bus is not used: one address bit picks which half of the address is loaded, and the address bits below it supply the new value.

While a transfer runs, the engine pulses `step` once per word moved. Each pulse moves the address forward by one word and lowers the count by one. The pulse that empties the count also drops the enable. The count register can be read back, and the two status bits above the count always read as one.

Top module: `dma_regs`

## Requirements
- R1: After reset the address, count, direction and enable are all zero, and the count readback is 0xC000.
- R2: A 16-bit count write stores `wrData[13:0] + 1` (modulo 2^14) as the count, `wrData[14]` as the direction and `wrData[15]` as the enable. The new values appear on the outputs after the next rising clock edge.
- R3: `cntRdData` always equals the current count in bits 13:0, with bits 15:14 reading 1.
- R4: A count write with `cntWide` low leaves the count, direction and enable unchanged.
- R5: An address write with `cpuAdr[14]` high loads address bits 21:9 from `cpuAdr[13:1]` and keeps address bits 8:0.
- R6: An address write with `cpuAdr[14]` low loads address bits 8:1 from `cpuAdr[8:1]` and keeps address bits 21:9. `cpuAdr[13:9]` have no effect.
- R7: Address bit 0 is always 0.
- R8: A `step` pulse while enabled adds 2 to the address, wrapping modulo 2^22, and subtracts 1 from the count.
- R9: A step that takes the count from 1 to 0 clears the enable. A step while disabled changes nothing.
- R10: When a register write and an enabled step land in the same cycle, the written register takes the written value and ignores the step. The register that is not written still steps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cntWr | input | 1 | Write strobe for the count register |
| cntWide | input | 1 | High when the count write is a 16-bit access |
| wrData | input | 16 | Write data for the count register |
| adrWr | input | 1 | Write strobe for the address register |
| cpuAdr | input | 14 | Processor address bits 14:1; bit 14 selects the half |
| step | input | 1 | One pulse per transferred word |
| cntRdData | output | 16 | Count readback with bits 15:14 set |
| dmaAddr | output | 22 | DMA byte address, always even |
| dmaCount | output | 14 | Words remaining |
| dmaDir | output | 1 | Direction flag |
| dmaEnable | output | 1 | DMA enable |

## Verification
A processor write and a transfer step can arrive in the same cycle. The bench provokes this by raising `step` together with `adrWr` while enabled, and again together with a 16-bit `cntWr`. It then checks that the written register holds exactly the written value, not a value moved by one step. It also checks that the other register advanced by exactly one step. The checker states the same rule cycle by cycle, and qualifies each stepping property with the absence of a write to that register.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  // Strobes from control to datapath, one per register action
  typedef struct packed {
    logic ldCnt;   // load count, direction and enable from data bus
    logic ldHi;    // load upper address field from CPU address lines
    logic ldLo;    // load lower address field from CPU address lines
    logic advAdr;  // advance address by one word
    logic advCnt;  // decrement count
  } dmaStrobe_t;
endpackage

// File: rtl/dma_regs_ctrl.sv
module dma_regs_ctrl
  import dma_regs_pkg::*;
(
  input  logic       cntWr,
  input  logic       cntWide,
  input  logic       adrWr,
  input  logic       adrSel,
  input  logic       step,
  input  logic       enable,
  output dmaStrobe_t stb
);
  logic advance;

  always_comb begin
    advance    = step & enable;
    stb.ldCnt  = cntWr & cntWide;
    stb.ldHi   = adrWr & adrSel;
    stb.ldLo   = adrWr & ~adrSel;
    // a write to a register takes priority over a step on that register
    stb.advCnt = advance & ~stb.ldCnt;
    stb.advAdr = advance & ~adrWr;
  end
endmodule

// File: rtl/dma_regs_dp.sv
module dma_regs_dp
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 14
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dmaStrobe_t              stb,
  input  logic [CNT_W+1:0]        wrData,
  input  logic [ADDR_W-LO_W-2:0]  adrBits,   // bit i carries CPU address bit i+1
  output logic [CNT_W+1:0]        cntRdData,
  output logic [ADDR_W-1:0]       dmaAddr,
  output logic [CNT_W-1:0]        dmaCount,
  output logic                    dmaDir,
  output logic                    dmaEnable
);
  localparam int WA_W = ADDR_W - 1;       // word address width
  localparam int HI_W = WA_W - LO_W;      // upper field width

  logic [WA_W-1:0]  wordAdr;
  logic [CNT_W-1:0] count;
  logic             dir;
  logic             en;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      dir   <= 1'b0;
      en    <= 1'b0;
    end else if (stb.ldCnt) begin
      count <= wrData[CNT_W-1:0] + CNT_W'(1);
      dir   <= wrData[CNT_W];
      en    <= wrData[CNT_W+1];
    end else if (stb.advCnt) begin
      count <= count - CNT_W'(1);
      if (count == CNT_W'(1)) en <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAdr <= '0;
    end else if (stb.ldHi) begin
      wordAdr[WA_W-1:LO_W] <= adrBits[HI_W-1:0];
    end else if (stb.ldLo) begin
      wordAdr[LO_W-1:0] <= adrBits[LO_W-1:0];
    end else if (stb.advAdr) begin
      wordAdr <= wordAdr + WA_W'(1);
    end
  end

  assign dmaAddr   = {wordAdr, 1'b0};
  assign dmaCount  = count;
  assign dmaDir    = dir;
  assign dmaEnable = en;
  assign cntRdData = {2'b11, count};
endmodule

// File: rtl/dma_regs.sv
module dma_regs
  import dma_regs_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cntWr,
  input  logic                   cntWide,
  input  logic [CNT_W+1:0]       wrData,
  input  logic                   adrWr,
  input  logic [ADDR_W-LO_W:1]   cpuAdr,
  input  logic                   step,
  output logic [CNT_W+1:0]       cntRdData,
  output logic [ADDR_W-1:0]      dmaAddr,
  output logic [CNT_W-1:0]       dmaCount,
  output logic                   dmaDir,
  output logic                   dmaEnable
);
  localparam int SEL_BIT = ADDR_W - LO_W;

  dmaStrobe_t stb;

  dma_regs_ctrl u_ctrl (
    .cntWr   (cntWr),
    .cntWide (cntWide),
    .adrWr   (adrWr),
    .adrSel  (cpuAdr[SEL_BIT]),
    .step    (step),
    .enable  (dmaEnable),
    .stb     (stb)
  );

  dma_regs_dp #(.ADDR_W(ADDR_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .adrBits   (cpuAdr[SEL_BIT-1:1]),
    .cntRdData (cntRdData),
    .dmaAddr   (dmaAddr),
    .dmaCount  (dmaCount),
    .dmaDir    (dmaDir),
    .dmaEnable (dmaEnable)
  );
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk #(
  parameter int ADDR_W = 22,
  parameter int LO_W   = 8,
  parameter int CNT_W  = 14
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cntWr,
  input logic                 cntWide,
  input logic [CNT_W+1:0]     wrData,
  input logic                 adrWr,
  input logic [ADDR_W-LO_W:1] cpuAdr,
  input logic                 step,
  input logic [CNT_W+1:0]     cntRdData,
  input logic [ADDR_W-1:0]    dmaAddr,
  input logic [CNT_W-1:0]     dmaCount,
  input logic                 dmaDir,
  input logic                 dmaEnable
);
  localparam int SEL = ADDR_W - LO_W;

  assert_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    cntRdData == {2'b11, dmaCount});

  assert_even_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    dmaAddr[0] == 1'b0);

  assert_count_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    cntWr && cntWide |=> dmaCount == CNT_W'($past(wrData[CNT_W-1:0]) + CNT_W'(1))
                         && dmaDir == $past(wrData[CNT_W])
                         && dmaEnable == $past(wrData[CNT_W+1]));

  assert_narrow_ignored_R4: assert property (@(posedge clk) disable iff (!rstN)
    cntWr && !cntWide && !step |=> $stable(dmaCount) && $stable(dmaEnable) && $stable(dmaDir));

  assert_hi_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    adrWr && cpuAdr[SEL] |=> dmaAddr[ADDR_W-1:LO_W+1] == $past(cpuAdr[SEL-1:1])
                            && dmaAddr[LO_W:0] == $past(dmaAddr[LO_W:0]));

  assert_lo_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    adrWr && !cpuAdr[SEL] |=> dmaAddr[LO_W:1] == $past(cpuAdr[LO_W:1])
                             && dmaAddr[ADDR_W-1:LO_W+1] == $past(dmaAddr[ADDR_W-1:LO_W+1]));

  assert_step_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    step && dmaEnable && !adrWr |=> dmaAddr == ADDR_W'($past(dmaAddr) + ADDR_W'(2)));

  assert_step_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    step && dmaEnable && !cntWr |=> dmaCount == CNT_W'($past(dmaCount) - CNT_W'(1)));

  assert_last_word_R9: assert property (@(posedge clk) disable iff (!rstN)
    step && dmaEnable && !cntWr && dmaCount == CNT_W'(1) |=> !dmaEnable);

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !cntWr && !adrWr && (!step || !dmaEnable) |=>
      $stable(dmaAddr) && $stable(dmaCount) && $stable(dmaEnable) && $stable(dmaDir));
endmodule

bind dma_regs dma_regs_chk #(.ADDR_W(ADDR_W), .LO_W(LO_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .cntWr(cntWr), .cntWide(cntWide), .wrData(wrData),
  .adrWr(adrWr), .cpuAdr(cpuAdr), .step(step), .cntRdData(cntRdData),
  .dmaAddr(dmaAddr), .dmaCount(dmaCount), .dmaDir(dmaDir), .dmaEnable(dmaEnable)
);

// File: tb/dma_regs_bench.sv
module dma_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntWr = 1'b0;
  logic        cntWide = 1'b0;
  logic [15:0] wrData = '0;
  logic        adrWr = 1'b0;
  logic [14:1] cpuAdr = '0;
  logic        step = 1'b0;
  logic [15:0] cntRdData;
  logic [21:0] dmaAddr;
  logic [13:0] dmaCount;
  logic        dmaDir;
  logic        dmaEnable;

  int nChecks = 0;
  int nFails  = 0;
  logic [21:0] expAdr = '0;
  logic [13:0] expCnt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_regs u_dma_regs (
    .clk(clk), .rstN(rstN), .cntWr(cntWr), .cntWide(cntWide), .wrData(wrData),
    .adrWr(adrWr), .cpuAdr(cpuAdr), .step(step), .cntRdData(cntRdData),
    .dmaAddr(dmaAddr), .dmaCount(dmaCount), .dmaDir(dmaDir), .dmaEnable(dmaEnable)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // inputs already set at a falling edge; wait one cycle and release them
  task automatic release_inputs();
    @(negedge clk);
    cntWr = 1'b0; cntWide = 1'b0; adrWr = 1'b0; step = 1'b0;
  endtask

  task automatic check_state(input string req, input logic [13:0] c,
                             input logic d, input logic e);
    check({req, " count"}, 32'(dmaCount), 32'(c));
    check({req, " dir"}, 32'(dmaDir), 32'(d));
    check({req, " enable"}, 32'(dmaEnable), 32'(e));
    check("R3 readback", 32'(cntRdData), 32'({2'b11, c}));
    check("R7 even address", 32'(dmaAddr[0]), 32'd0);
  endtask

  task automatic t_reset();
    check("R1 address", 32'(dmaAddr), 32'd0);
    check_state("R1", 14'd0, 1'b0, 1'b0);
    check("R1 readback", 32'(cntRdData), 32'h0000_C000);
  endtask

  task automatic t_count_write(input logic [15:0] d);
    cntWr = 1'b1; cntWide = 1'b1; wrData = d;
    release_inputs();
    expCnt = d[13:0] + 14'd1;
    check_state("R2", expCnt, d[14], d[15]);
  endtask

  task automatic t_narrow_write();
    cntWr = 1'b1; cntWide = 1'b0; wrData = 16'h4123;
    release_inputs();
    check_state("R4 narrow write ignored", expCnt, 1'b1, 1'b0);
  endtask

  task automatic t_addr_hi(input logic [12:0] hi);
    adrWr = 1'b1; cpuAdr = {1'b1, hi};
    release_inputs();
    expAdr[21:9] = hi;
    check("R5 high load", 32'(dmaAddr), 32'(expAdr));
  endtask

  task automatic t_addr_lo(input logic [7:0] lo);
    adrWr = 1'b1; cpuAdr = {1'b0, 5'b10101, lo};
    release_inputs();
    expAdr[8:1] = lo;
    check("R6 low load", 32'(dmaAddr), 32'(expAdr));
  endtask

  task automatic t_step(input logic expEn);
    step = 1'b1;
    release_inputs();
    expAdr = expAdr + 22'd2;
    expCnt = expCnt - 14'd1;
    check("R8 step address", 32'(dmaAddr), 32'(expAdr));
    check("R8 step count", 32'(dmaCount), 32'(expCnt));
    check("R9 enable after step", 32'(dmaEnable), 32'(expEn));
  endtask

  task automatic t_step_disabled();
    step = 1'b1;
    release_inputs();
    check("R9 disabled step address", 32'(dmaAddr), 32'(expAdr));
    check("R9 disabled step count", 32'(dmaCount), 32'(expCnt));
  endtask

  task automatic t_collide();
    // address write with step: address takes written value, count steps
    adrWr = 1'b1; cpuAdr = {1'b0, 5'b00000, 8'h11}; step = 1'b1;
    release_inputs();
    expAdr[8:1] = 8'h11;
    expCnt = expCnt - 14'd1;
    check("R10 address write wins", 32'(dmaAddr), 32'(expAdr));
    check("R10 count steps", 32'(dmaCount), 32'(expCnt));
    // count write with step: count takes written value, address steps
    cntWr = 1'b1; cntWide = 1'b1; wrData = 16'h8007; step = 1'b1;
    release_inputs();
    expAdr = expAdr + 22'd2;
    expCnt = 14'd8;
    check("R10 count write wins", 32'(dmaCount), 32'(expCnt));
    check("R10 address steps", 32'(dmaAddr), 32'(expAdr));
    check("R10 enable loaded", 32'(dmaEnable), 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_count_write(16'h8005);          // count 6, enabled
    t_count_write(16'h7FFF);          // count wraps to 0, direction set
    t_narrow_write();
    t_addr_hi(13'h1ABC);
    t_addr_lo(8'hA5);
    t_addr_hi(13'h0F0F);              // low field kept
    t_count_write(16'h8002);          // count 3
    t_step(1'b1);
    t_step(1'b1);
    t_step(1'b0);                     // 1 -> 0 clears enable
    t_step_disabled();
    t_addr_hi(13'h1FFF);
    t_addr_lo(8'hFF);
    t_count_write(16'h8004);          // count 5
    t_step(1'b1);                     // address wraps to 0
    check("R8 address wrap", 32'(dmaAddr), 32'd0);
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule